// File: doc/BRIEF.md
# Supply-Loss Write Guard for a Byte-Wide Register Array

This block sits between a host's byte-wide memory strobes and a small on-chip register array, and decides, cycle by cycle, whether an access may reach that array. It watches three digital supply flags from external comparators. The first says the supply is above the upper deselect level. The second says it is above the lower deselect level. The third says it is above the level at which a backup cell must take over.

While the supply is healthy, reads and writes pass straight through. When the upper or lower flag drops, the array is cut off in the same cycle. Writes are discarded, the read path stops driving, and the strobes are ignored.

Access comes back only after a parameterised quiet interval. That interval is counted from the edge where both deselect flags are seen high again, and the count restarts if either flag falls during it. The block must then also see chip enable idle for one cycle. Dropping below the switchover level selects the backup source until the flag returns.

Top module: `pfail_guard`

## Requirements
- R1: In state NORMAL with both deselect flags high, a write (ce_n=0, we_n=0) stores wdata at addr on the clock edge. A read (ce_n=0, oe_n=0, we_n=1) drives the stored byte on rdata with rdata_oe=1 in the same cycle.
- R2: In any state other than NORMAL, or while either deselect flag is low, no array location changes, rdata_oe is 0 and rdata is 0, whatever the strobes, address and data inputs do.
- R3: Dropping the upper flag blocks access and raises wprot combinationally in that cycle. With the switchover flag high, state_o becomes PROTECT on the next edge.
- R4: With the switchover flag low, the next edge moves to BATTERY and batt_sel=1. When the flag returns, the next edge moves to PROTECT and batt_sel=0.
- R5: During and straight after reset the state is PROTECT, wprot=1, batt_sel=0 and rdata_oe=0.
- R6: The edge that sees both deselect flags high in PROTECT enters RECOVER. The block stays in RECOVER for at least RECOVERY_CYCLES+1 edges. A drop of either flag during RECOVER returns it to PROTECT, so a later recovery starts counting from zero.
- R7: The move from RECOVER to NORMAL happens only on an edge where ce_n=1. While ce_n stays 0, the block remains in RECOVER past the interval.
- R8: A write whose cycle coincides with the upper flag dropping leaves the whole array unchanged, including the addressed location.
- R9: state_o codes are NORMAL=0, PROTECT=1, BATTERY=2 and RECOVER=3. wprot is 1 exactly when access is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_hi | input | 1 | Supply above upper deselect level |
| sup_lo | input | 1 | Supply above lower deselect level |
| sup_sw | input | 1 | Supply above backup switchover level |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Drive enable for the read data pins |
| batt_sel | output | 1 | Backup source selected |
| wprot | output | 1 | Access blocked |
| state_o | output | 2 | Current supervisor state |

## Verification
The bench builds the block with RECOVERY_CYCLES=8 and the default 16-entry, 8-bit array. The short interval makes the exact edge of the move out of RECOVER observable. It also makes room for several full recoveries in one run: a restart after a single-cycle flag glitch, and a recovery held back by a chip enable kept low. The small array lets every location be read back after each protection episode, which shows that blocked and aborted writes touched nothing.

// File: rtl/pfail_pkg.sv
package pfail_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BATTERY = 2'd2,
    ST_RECOVER = 2'd3
  } pf_state_t;
endpackage

// File: rtl/pfail_fsm.sv
module pfail_fsm
  import pfail_pkg::*;
#(
  parameter int RECOVERY_CYCLES = 1000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sup_hi,
  input  logic      sup_lo,
  input  logic      sup_sw,
  input  logic      ce_n,
  output pf_state_t state,
  output logic      access_ok
);
  localparam int CW = $clog2(RECOVERY_CYCLES + 1);
  localparam logic [CW-1:0] CNT_END = CW'(RECOVERY_CYCLES);

  pf_state_t     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          sup_ok;

  assign sup_ok = sup_hi && sup_lo;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!sup_sw) begin
      st_d = ST_BATTERY;
    end else begin
      case (st_q)
        ST_NORMAL:  if (!sup_ok) st_d = ST_PROTECT;
        ST_PROTECT: if (sup_ok) begin
                      st_d   = ST_RECOVER;
                      cnt_d  = '0;
                      cnt_en = 1'b1;
                    end
        ST_BATTERY: st_d = ST_PROTECT;
        ST_RECOVER: begin
          if (!sup_ok) begin
            st_d = ST_PROTECT;
          end else if (cnt_q == CNT_END) begin
            if (ce_n) st_d = ST_NORMAL;
          end else begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: st_d = ST_PROTECT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PROTECT;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign state     = st_q;
  assign access_ok = (st_q == ST_NORMAL) && sup_ok;

  // R3: losing the upper flag in NORMAL lands in PROTECT
  a_r3_drop_to_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && sup_sw && !sup_hi) |=> (st_q == ST_PROTECT));

  // R6: a drop during recovery restarts from PROTECT
  a_r6_recover_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECOVER && sup_sw && !sup_hi) |=> (st_q == ST_PROTECT));

  // R7: NORMAL is entered only from RECOVER with chip enable idle
  a_r7_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NORMAL && $past(st_q) != ST_NORMAL)
      |-> ($past(st_q) == ST_RECOVER && $past(ce_n)));
endmodule

// File: rtl/pfail_array.sv
module pfail_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (hit) mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfail_pkg::*;
#(
  parameter int ADDR_W          = 4,
  parameter int DATA_W          = 8,
  parameter int RECOVERY_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sup_hi,
  input  logic              sup_lo,
  input  logic              sup_sw,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              batt_sel,
  output logic              wprot,
  output logic [1:0]        state_o
);
  pf_state_t         state;
  logic              access_ok;
  logic              wr_en;
  logic [DATA_W-1:0] arr_rdata;

  pfail_fsm #(.RECOVERY_CYCLES(RECOVERY_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_hi    (sup_hi),
    .sup_lo    (sup_lo),
    .sup_sw    (sup_sw),
    .ce_n      (ce_n),
    .state     (state),
    .access_ok (access_ok)
  );

  assign wr_en = access_ok && !ce_n && !we_n;

  pfail_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (arr_rdata)
  );

  assign rdata_oe = access_ok && !ce_n && !oe_n && we_n;
  assign rdata    = rdata_oe ? arr_rdata : '0;
  assign batt_sel = (state == ST_BATTERY);
  assign wprot    = !access_ok;
  assign state_o  = state;

  // R2: outside NORMAL the read pins stay undriven
  a_r2_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0) |-> (!rdata_oe && rdata == '0));

  // R4: switchover flag low selects the backup source on the next edge
  a_r4_backup_on: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_sw |=> batt_sel);

  // R4: switchover flag back releases the backup source
  a_r4_backup_off: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_sel && sup_sw) |=> (!batt_sel && state_o == 2'd1));
endmodule

// File: tb/sim_pfail_guard.sv
module sim_pfail_guard;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int REC = 8;
  localparam int N   = 1 << AW;

  logic          clk, rst_n, sup_hi, sup_lo, sup_sw, ce_n, we_n, oe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_oe, batt_sel, wprot;
  logic [1:0]    state_o;

  int n_run, n_fail;
  bit done;
  logic [DW-1:0] mdl [N];
  logic [DW:0]   exp_q[$];
  string         tag_q[$];

  pfail_guard #(.ADDR_W(AW), .DATA_W(DW), .RECOVERY_CYCLES(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_hi(sup_hi), .sup_lo(sup_lo), .sup_sw(sup_sw),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe), .batt_sel(batt_sel), .wprot(wprot),
    .state_o(state_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = AW'(a); wdata = DW'(d);
    tick(1);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  // driver: push expected {oe,data} and hold the read over one negedge
  task automatic rd(input int a, input bit eoe, input int ed, input string tag);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = AW'(a);
    exp_q.push_back({eoe, DW'(ed)});
    tag_q.push_back(tag);
    tick(1);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  // monitor
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      logic [DW:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'({rdata_oe, rdata}), int'(e));
    end
  end

  task automatic read_all(input string tag);
    for (int a = 0; a < N; a++) rd(a, 1'b1, mdl[a], tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; sup_hi = 1'b1; sup_lo = 1'b1; sup_sw = 1'b1;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; wdata = '0;
    #12;
    chk("R5 state", state_o, 1);
    chk("R5 wprot", wprot, 1);
    chk("R5 batt", batt_sel, 0);
    chk("R5 oe", rdata_oe, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(REC + 1);
    chk("R6 still recovering", state_o, 3);
    chk("R9 wprot in recover", wprot, 1);
    tick(1);
    chk("R6 normal after interval", state_o, 0);
    chk("R9 wprot clear", wprot, 0);

    for (int a = 0; a < N; a++) begin
      mdl[a] = DW'(a * 17) ^ 8'h5A;
      wr(a, mdl[a]);
    end
    read_all("R1");

    sup_hi = 1'b0; #1;
    chk("R3 wprot same cycle", wprot, 1);
    rd(2, 1'b0, 0, "R2 blocked read");
    chk("R3 protect", state_o, 1);
    wr(6, 8'hFF);
    sup_hi = 1'b1;
    tick(REC + 3);
    chk("R6 back to normal", state_o, 0);

    ce_n = 1'b0; we_n = 1'b0; addr = 4'd5; wdata = ~mdl[5]; sup_hi = 1'b0;
    tick(1);
    ce_n = 1'b1; we_n = 1'b1;
    chk("R8 protect after abort", state_o, 1);
    sup_hi = 1'b1;
    tick(REC + 3);
    read_all("R8");

    sup_sw = 1'b0; sup_hi = 1'b0; sup_lo = 1'b0;
    tick(1);
    chk("R4 batt on", batt_sel, 1);
    chk("R9 battery code", state_o, 2);
    rd(1, 1'b0, 0, "R2 read in battery");
    wr(7, 8'h00);
    sup_sw = 1'b1;
    tick(1);
    chk("R4 batt off", batt_sel, 0);
    chk("R4 protect", state_o, 1);
    sup_lo = 1'b1;
    tick(3);
    chk("R2 window hold", state_o, 1);
    rd(3, 1'b0, 0, "R2 window read");

    sup_hi = 1'b1;
    tick(4);
    sup_hi = 1'b0;
    tick(1);
    chk("R6 glitch protect", state_o, 1);
    sup_hi = 1'b1;
    tick(REC + 1);
    chk("R6 restart counted", state_o, 3);
    tick(1);
    chk("R6 normal after restart", state_o, 0);

    sup_hi = 1'b0;
    tick(1);
    sup_hi = 1'b1; ce_n = 1'b0;
    tick(REC + 5);
    chk("R7 held by ce", state_o, 3);
    ce_n = 1'b1;
    tick(1);
    chk("R7 normal on idle ce", state_o, 0);

    read_all("R8 final");
    wr(9, 8'hC3); mdl[9] = 8'hC3;
    rd(9, 1'b1, 8'hC3, "R1 write after recovery");
    tick(2);
    finish_run();
  end
endmodule